// File: doc/BRIEF.md
# Ripple-Carry Adder-Subtractor

This block is a combinational unit that adds or subtracts two unsigned operands of `WIDTH` bits. The default width is 4. One mode input selects the operation, and it does two jobs at once. It conditions every bit of the second operand through an exclusive-OR, and it is also the carry into the lowest column. With the mode high the unit forms A + ~B + 1, which is the two's-complement difference A − B.

The datapath is a chain of identical one-bit full adders. Each column passes its carry to the next more significant column. The carry leaving the top column is exclusive-ORed with the mode bit before it reaches the output. In add mode that output is a plain carry, and in subtract mode it is a borrow.

The block has no clock or state. Its outputs follow its inputs after the ripple delay, and it can sit inside any pipeline stage that has the timing budget for a `WIDTH`-column carry chain.

Top module: `addsub_unit`

## Requirements
- R1: With `sub_i` = 0 the second operand enters the adder unchanged, so `sum_o` = (A + B) mod 2^WIDTH.
- R2: With `sub_i` = 1 every bit of the second operand is inverted before it enters the adder.
- R3: The carry into bit 0 equals `sub_i`, so with `sub_i` = 1 the result `sum_o` = (A + ~B + 1) mod 2^WIDTH = (A − B) mod 2^WIDTH.
- R4: With `sub_i` = 0, `carry_o` is 1 exactly when A + B ≥ 2^WIDTH.
- R5: With `sub_i` = 1, `carry_o` is the top carry exclusive-ORed with the mode bit. It is 1 exactly when A < B as unsigned numbers.
- R6: Each column produces sum = (a ^ b) ^ cin and carry = a·b + (a ^ b)·cin, so {carry, sum} equals a + b + cin.
- R7: Carries ripple from each column into the next more significant one. A carry that starts at bit 0 can propagate through every column, for example A = all ones with B = 1.
- R8: All 2^(2·WIDTH+1) combinations of A, B and the mode give results that match reference arithmetic modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| sub_i | input | 1 | Mode: 0 = add, 1 = subtract |
| sum_o | output | WIDTH | Sum or difference modulo 2^WIDTH |
| carry_o | output | 1 | Carry out in add mode, borrow in subtract mode |

## Verification
The assertions are immediate checks inside combinational processes. They assume that every input is a settled, known 0 or 1 whenever the checks evaluate, with no X or Z on the operands or the mode.

The bench drives all inputs together from tasks. It then waits a fixed settling time before it samples the outputs, so every assertion sees a fully resolved carry chain. The stimulus never leaves an input floating, and the mode is always a defined 0 or 1.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned ADDSUB_W = 4;

  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } addsub_mode_e;
endpackage

// File: rtl/addsub_full_adder.sv
module addsub_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half_x;

  always_comb begin
    half_x = a_i ^ b_i;
    s_o    = half_x ^ c_i;
    c_o    = (a_i & b_i) | (half_x & c_i);
  end

  // R6: column result equals the arithmetic sum of its three inputs
  always_comb begin
    a_r6_column_sum: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {1'b0, c_i}))
      else $error("column sum mismatch");
  end
endmodule

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] b_o
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_xor
    assign b_o[k] = b_i[k] ^ sub_i;
  end

  always_comb begin
    // R1: pass-through in add mode
    a_r1_pass: assert (sub_i || (b_o == b_i)) else $error("operand altered in add mode");
    // R2: bitwise complement in subtract mode
    a_r2_invert: assert (!sub_i || (((b_o & b_i) == '0) && ((b_o | b_i) == '1)))
      else $error("operand not inverted in subtract mode");
  end
endmodule

// File: rtl/addsub_ripple_chain.sv
module addsub_ripple_chain #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o
);
  logic [WIDTH:0] carry_q;

  assign carry_q[0] = c_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_col
    addsub_full_adder col_i (
      .a_i (a_i[k]),
      .b_i (b_i[k]),
      .c_i (carry_q[k]),
      .s_o (s_o[k]),
      .c_o (carry_q[k+1])
    );
  end

  assign c_o = carry_q[WIDTH];

  // R7: rippled chain matches a full-width addition
  always_comb begin
    a_r7_chain_sum: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i}))
      else $error("ripple chain mismatch");
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = ADDSUB_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  addsub_mode_e mode;
  logic [WIDTH-1:0] b_cond;
  logic             top_carry;

  assign mode = addsub_mode_e'(sub_i);

  addsub_operand_cond #(.WIDTH(WIDTH)) cond_i (
    .b_i   (b_i),
    .sub_i (sub_i),
    .b_o   (b_cond)
  );

  // mode doubles as carry-in for the +1 of two's complement
  addsub_ripple_chain #(.WIDTH(WIDTH)) chain_i (
    .a_i (a_i),
    .b_i (b_cond),
    .c_i (sub_i),
    .s_o (sum_o),
    .c_o (top_carry)
  );

  // raw carry is inverted sense in subtract mode
  assign carry_o = top_carry ^ sub_i;

  always_comb begin
    // R4: add mode gives full sum with carry
    a_r4_add_carry: assert (mode != MODE_ADD ||
                            ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i})))
      else $error("add result mismatch");
    // R3: subtract mode gives modular difference
    a_r3_difference: assert (mode != MODE_SUB || (sum_o == WIDTH'(a_i - b_i)))
      else $error("difference mismatch");
    // R5: borrow flags unsigned A < B
    a_r5_borrow: assert (mode != MODE_SUB || (carry_o == (a_i < b_i)))
      else $error("borrow mismatch");
  end
endmodule

// File: tb/addsub_unit_tb_top.sv
module addsub_unit_tb_top;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic [W-1:0] a_s = '0;
  logic [W-1:0] b_s = '0;
  logic         sub_s = 1'b0;
  logic [W-1:0] sum_s;
  logic         carry_s;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addsub_unit #(.WIDTH(W)) dut_i (
    .a_i     (a_s),
    .b_i     (b_s),
    .sub_i   (sub_s),
    .sum_o   (sum_s),
    .carry_o (carry_s)
  );

  task automatic apply(input int a, input int b, input bit s);
    a_s   = W'(a);
    b_s   = W'(b);
    sub_s = s;
    #2;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (a=%0d b=%0d sub=%0b)",
               req, got, exp, a_s, b_s, sub_s);
    end
  endtask

  function automatic int ref_sum(input int a, input int b, input bit s);
    return s ? ((a - b + M) % M) : ((a + b) % M);
  endfunction

  function automatic int ref_carry(input int a, input int b, input bit s);
    return s ? int'(a < b) : int'(a + b >= M);
  endfunction

  // idle state: all-zero inputs give zero outputs
  task automatic t_idle();
    apply(0, 0, 1'b0);
    chk("R1 idle sum", sum_s, 0);
    chk("R4 idle carry", carry_s, 0);
  endtask

  task automatic t_add();
    apply(5, 3, 1'b0);
    chk("R1 add sum", sum_s, 8);
    chk("R4 add no carry", carry_s, 0);
    apply(9, 8, 1'b0);
    chk("R1 add wrap sum", sum_s, 1);
    chk("R4 add carry", carry_s, 1);
  endtask

  task automatic t_sub();
    apply(7, 2, 1'b1);
    chk("R3 sub diff", sum_s, 5);
    chk("R5 no borrow", carry_s, 0);
    apply(2, 7, 1'b1);
    chk("R3 sub wrap diff", sum_s, 11);
    chk("R5 borrow", carry_s, 1);
    apply(6, 6, 1'b1);
    chk("R5 equal no borrow", carry_s, 0);
    chk("R2 equal diff zero", sum_s, 0);
    apply(0, 0, 1'b1);
    chk("R2 zero minus zero", sum_s, 0);
    chk("R3 carry-in cancels inversion", carry_s, 0);
  endtask

  task automatic t_ripple();
    apply(M - 1, 1, 1'b0);
    chk("R7 full ripple sum", sum_s, 0);
    chk("R7 full ripple carry", carry_s, 1);
    apply(0, 1, 1'b1);
    chk("R7 borrow ripple diff", sum_s, M - 1);
    chk("R6 borrow ripple flag", carry_s, 1);
    apply(M - 1, M - 1, 1'b0);
    chk("R6 all ones add", sum_s, M - 2);
    chk("R6 all ones carry", carry_s, 1);
  endtask

  task automatic t_exhaustive();
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++) begin
          apply(a, b, s[0]);
          chk("R8 sum", sum_s, ref_sum(a, b, s[0]));
          chk("R8 carry", carry_s, ref_carry(a, b, s[0]));
        end
  endtask

  initial begin
    @(negedge clk);
    t_idle();
    t_add();
    t_sub();
    t_ripple();
    t_exhaustive();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule